// File: doc/BRIEF.md
# Task Context Switch Sequencer

This block performs the memory traffic of a hardware task switch. A pulse on `start` hands it two physical base addresses and a snapshot of the outgoing task's working registers. It first stores those registers into the outgoing task's state segment. It then reads the whole 104-byte context area of the incoming task's segment. Every access goes through a single 32-bit request/response port. Each transfer completes only on a cycle in which the block presents a request and the memory side signals ready.

The fields read back are held on dedicated outputs until the next switch: the page-directory base for the control register, the three privileged-level stack pointers (each a selector plus a 32-bit offset), the trap flag, the I/O bitmap offset and the sixteen working-register words. After the last read, the block spends one cycle evaluating the trap flag. It then raises a one-cycle completion pulse. When the incoming segment has its trap flag set, the completion pulse comes with a debug-exception request.

Every address is the segment base plus a constant word stride, and no address is recomputed or translated during the sequence. Both bases are assumed to be word aligned.

Top module: `task_ctx_switcher`

## Requirements
- R1: A synchronous active-high reset returns the block to idle. It drives `busy`, `done`, `dbg_req` and `mem_valid` low and sets every loaded-field output to zero.
- R2: A `start` seen while idle raises `busy` on the next cycle and begins the save phase of 16 writes (`mem_we`=1). The writes go to `old_base`+32, +36, … +92 in that order. Write k carries word k of `save_ctx` (bits 32k+31:32k), taken as it stood on the start cycle. No write goes to any other offset, so the stack pointer words at offsets 4 to 24 are never rewritten.
- R3: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged. A transfer completes only on a clock edge where both are high.
- R4: After the last write completes, the block issues 26 reads (`mem_we`=0) at `new_base`+0, +4, … +100 in ascending order.
- R5: For privilege level l (0 to 2), the read word at byte 4+8l becomes `stk_off[32l+31:32l]`. Bits 15:0 of the word at byte 8+8l become `stk_sel[16l+15:16l]`.
- R6: The word read at byte 28 becomes `pgdir_base`.
- R7: The word read at byte 32+4k (k = 0 to 15) becomes `load_ctx` word k. When the old and new segments are the same, the loaded words therefore equal the saved ones.
- R8: From the word read at byte 100, bit 0 drives `trap_flag` and bits 31:16 drive `io_map_ofs` unchanged. `dbg_req` is high only in the `done` cycle, and only if that bit was set.
- R9: `done` is a one-cycle pulse. It is high in the second cycle after the clock edge that completes the last read. `busy` stays high from the cycle after start through the `done` cycle and falls on the next cycle.
- R10: A `start` pulse while `busy` is high is ignored. The running sequence, its base addresses and its save data are all unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a switch (accepted only when idle) |
| old_base | input | ADDR_W | Physical base of the outgoing segment |
| new_base | input | ADDR_W | Physical base of the incoming segment |
| save_ctx | input | 512 | Sixteen outgoing working-register words |
| mem_valid | output | 1 | Memory request present |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Physical byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts or answers the request this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` on a read |
| busy | output | 1 | A switch is in progress |
| done | output | 1 | One-cycle completion pulse |
| dbg_req | output | 1 | Debug-exception request, with `done` |
| pgdir_base | output | 32 | Loaded page-directory base |
| stk_off | output | 96 | Loaded stack offsets, level l at bits 32l+31:32l |
| stk_sel | output | 48 | Loaded stack selectors, level l at bits 16l+15:16l |
| trap_flag | output | 1 | Loaded trap flag |
| io_map_ofs | output | 16 | Loaded I/O bitmap offset |
| load_ctx | output | 512 | Loaded working-register words |

## Verification
The first write is presented in the cycle after `start` is accepted. Each transfer then advances only on an edge where it is acknowledged. A loaded field appears on its output in the cycle after its read is acknowledged. `done`, and `dbg_req` if the trap bit was set, follow two cycles after the last read is acknowledged, and `busy` drops one cycle later. The bench model advances on the same rising edges, using the same inputs the design sees. It compares every output half a period later, on the falling edge. Field outputs are checked only in the idle and completion states, so the design's earlier, field-by-field updates during the load phase are never mistaken for errors.

// File: rtl/task_ctx_pkg.sv
`timescale 1ns/1ps
package task_ctx_pkg;

    // Context area geometry
    localparam int unsigned WORD_W      = 32;
    localparam int unsigned WORD_BYTES  = WORD_W / 8;
    localparam int unsigned WORD_SHIFT  = $clog2(WORD_BYTES);
    localparam int unsigned AREA_BYTES  = 104;
    localparam int unsigned AREA_WORDS  = AREA_BYTES / WORD_BYTES;
    localparam int unsigned IDX_W       = $clog2(AREA_WORDS);

    // Word indices whose position the decode depends on
    localparam int unsigned PRIV_LEVELS = 3;
    localparam int unsigned STACK_FIRST = 1;
    localparam int unsigned PGDIR_WORD  = 7;
    localparam int unsigned LIVE_FIRST  = 8;
    localparam int unsigned LIVE_WORDS  = 16;
    localparam int unsigned LIVE_IDX_W  = $clog2(LIVE_WORDS);
    localparam int unsigned FLAG_WORD   = AREA_WORDS - 1;
    localparam int unsigned TRAP_BIT    = 0;
    localparam int unsigned IOMAP_LSB   = 16;
    localparam int unsigned IOMAP_W     = 16;
    localparam int unsigned SEL_W       = 16;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_SAVE_OLD,
        SEQ_LOAD_NEW,
        SEQ_CHECK_FLAGS,
        SEQ_DONE
    } seq_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] offset;
        logic [SEL_W-1:0]  selector;
    } stack_ptr_t;

    typedef struct packed {
        logic               trap;
        logic [IOMAP_W-1:0] io_map;
    } flag_word_t;

    // Word index holding the stack offset for a privilege level
    function automatic logic [IDX_W-1:0] stack_off_word(input int lvl);
        return IDX_W'(int'(STACK_FIRST) + 2 * lvl);
    endfunction

    // Word index holding the stack selector for a privilege level
    function automatic logic [IDX_W-1:0] stack_sel_word(input int lvl);
        return IDX_W'(int'(STACK_FIRST) + 2 * lvl + 1);
    endfunction

    function automatic flag_word_t decode_flags(input logic [WORD_W-1:0] w);
        flag_word_t f;
        f.trap   = w[TRAP_BIT];
        f.io_map = w[IOMAP_LSB +: IOMAP_W];
        return f;
    endfunction

endpackage

// File: rtl/tcs_seq_ctrl.sv
`timescale 1ns/1ps
module tcs_seq_ctrl
    import task_ctx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             mem_ready,
    output seq_state_e       state,
    output logic [IDX_W-1:0] idx,
    output logic             accept,
    output logic             mem_valid,
    output logic             mem_we,
    output logic             load_fire,
    output logic             busy,
    output logic             done
);

    seq_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             last_save;
    logic             last_load;

    assign last_save = (idx_q == IDX_W'(LIVE_WORDS - 1));
    assign last_load = (idx_q == IDX_W'(AREA_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_SAVE_OLD;
                        idx_q   <= '0;
                    end
                end
                SEQ_SAVE_OLD: begin
                    if (mem_ready) begin
                        if (last_save) begin
                            state_q <= SEQ_LOAD_NEW;
                            idx_q   <= '0;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                SEQ_LOAD_NEW: begin
                    if (mem_ready) begin
                        if (last_load) begin
                            state_q <= SEQ_CHECK_FLAGS;
                            idx_q   <= '0;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                SEQ_CHECK_FLAGS: state_q <= SEQ_DONE;
                SEQ_DONE:        state_q <= SEQ_IDLE;
                default:         state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign state     = state_q;
    assign idx       = idx_q;
    assign accept    = (state_q == SEQ_IDLE) && start;
    assign mem_valid = (state_q == SEQ_SAVE_OLD) || (state_q == SEQ_LOAD_NEW);
    assign mem_we    = (state_q == SEQ_SAVE_OLD);
    assign load_fire = (state_q == SEQ_LOAD_NEW) && mem_ready;
    assign busy      = (state_q != SEQ_IDLE);
    assign done      = (state_q == SEQ_DONE);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R10
    start_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_LOAD_NEW && start) |=> (state_q != SEQ_SAVE_OLD));

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R4
    load_follows_save_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_SAVE_OLD && mem_ready && last_save) |=> (mem_valid && !mem_we && idx_q == '0));

endmodule

// File: rtl/tcs_addr_gen.sv
`timescale 1ns/1ps
module tcs_addr_gen
    import task_ctx_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] old_base_i,
    input  logic [ADDR_W-1:0] new_base_i,
    input  seq_state_e        state,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] SAVE_LO = ADDR_W'(LIVE_FIRST * WORD_BYTES);
    localparam logic [ADDR_W-1:0] SAVE_HI = ADDR_W'((LIVE_FIRST + LIVE_WORDS - 1) * WORD_BYTES);
    localparam logic [ADDR_W-1:0] AREA_SZ = ADDR_W'(AREA_BYTES);

    logic [ADDR_W-1:0] old_q;
    logic [ADDR_W-1:0] new_q;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] word_num;

    always_ff @(posedge clk) begin
        if (rst) begin
            old_q <= '0;
            new_q <= '0;
        end else if (accept) begin
            old_q <= old_base_i;
            new_q <= new_base_i;
        end
    end

    always_comb begin
        if (state == SEQ_SAVE_OLD) begin
            base     = old_q;
            word_num = ADDR_W'(LIVE_FIRST) + ADDR_W'(idx);
        end else begin
            base     = new_q;
            word_num = ADDR_W'(idx);
        end
        addr = base + (word_num << WORD_SHIFT);
    end

    // R2
    save_window_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_SAVE_OLD) |-> ((addr - old_q) >= SAVE_LO && (addr - old_q) <= SAVE_HI));

    // R4
    load_window_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_LOAD_NEW) |-> ((addr - new_q) < AREA_SZ));

endmodule

// File: rtl/tcs_save_buf.sv
`timescale 1ns/1ps
module tcs_save_buf
    import task_ctx_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         accept,
    input  logic [LIVE_WORDS*WORD_W-1:0] ctx_i,
    input  logic [LIVE_IDX_W-1:0]        sel,
    output logic [WORD_W-1:0]            wdata
);

    logic [WORD_W-1:0] words_q [LIVE_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < LIVE_WORDS; w++) words_q[w] <= '0;
        end else if (accept) begin
            for (int w = 0; w < LIVE_WORDS; w++) words_q[w] <= ctx_i[w*WORD_W +: WORD_W];
        end
    end

    assign wdata = words_q[sel];

endmodule

// File: rtl/tcs_load_regs.sv
`timescale 1ns/1ps
module tcs_load_regs
    import task_ctx_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load_fire,
    input  logic [IDX_W-1:0]             idx,
    input  logic [WORD_W-1:0]            rdata,
    output logic [WORD_W-1:0]            pgdir_o,
    output stack_ptr_t [PRIV_LEVELS-1:0] stack_o,
    output flag_word_t                   flags_o,
    output logic [LIVE_WORDS*WORD_W-1:0] live_o
);

    logic [WORD_W-1:0]            pgdir_q;
    stack_ptr_t [PRIV_LEVELS-1:0] stack_q;
    flag_word_t                   flags_q;
    logic [WORD_W-1:0]            live_q [LIVE_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            pgdir_q <= '0;
            stack_q <= '0;
            flags_q <= '0;
            for (int w = 0; w < LIVE_WORDS; w++) live_q[w] <= '0;
        end else if (load_fire) begin
            for (int l = 0; l < PRIV_LEVELS; l++) begin
                if (idx == stack_off_word(l)) stack_q[l].offset   <= rdata;
                if (idx == stack_sel_word(l)) stack_q[l].selector <= rdata[SEL_W-1:0];
            end
            if (idx == IDX_W'(PGDIR_WORD)) pgdir_q <= rdata;
            if (idx == IDX_W'(FLAG_WORD))  flags_q <= decode_flags(rdata);
            for (int w = 0; w < LIVE_WORDS; w++) begin
                if (idx == IDX_W'(LIVE_FIRST + w)) live_q[w] <= rdata;
            end
        end
    end

    assign pgdir_o = pgdir_q;
    assign stack_o = stack_q;
    assign flags_o = flags_q;

    genvar w;
    generate
        for (w = 0; w < LIVE_WORDS; w++) begin : g_live_out
            assign live_o[w*WORD_W +: WORD_W] = live_q[w];
        end
    endgenerate

    // R6
    pgdir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load_fire |=> $stable(pgdir_q));

    // R8
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load_fire |=> $stable(flags_q));

endmodule

// File: rtl/task_ctx_switcher.sv
`timescale 1ns/1ps
module task_ctx_switcher
    import task_ctx_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [ADDR_W-1:0]             old_base,
    input  logic [ADDR_W-1:0]             new_base,
    input  logic [LIVE_WORDS*WORD_W-1:0]  save_ctx,
    output logic                          mem_valid,
    output logic                          mem_we,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [WORD_W-1:0]             mem_wdata,
    input  logic                          mem_ready,
    input  logic [WORD_W-1:0]             mem_rdata,
    output logic                          busy,
    output logic                          done,
    output logic                          dbg_req,
    output logic [WORD_W-1:0]             pgdir_base,
    output logic [PRIV_LEVELS*WORD_W-1:0] stk_off,
    output logic [PRIV_LEVELS*SEL_W-1:0]  stk_sel,
    output logic                          trap_flag,
    output logic [IOMAP_W-1:0]            io_map_ofs,
    output logic [LIVE_WORDS*WORD_W-1:0]  load_ctx
);

    seq_state_e                   state;
    logic [IDX_W-1:0]             idx;
    logic                         accept;
    logic                         load_fire;
    stack_ptr_t [PRIV_LEVELS-1:0] stack;
    flag_word_t                   flags;

    tcs_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mem_ready (mem_ready),
        .state     (state),
        .idx       (idx),
        .accept    (accept),
        .mem_valid (mem_valid),
        .mem_we    (mem_we),
        .load_fire (load_fire),
        .busy      (busy),
        .done      (done)
    );

    tcs_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .old_base_i (old_base),
        .new_base_i (new_base),
        .state      (state),
        .idx        (idx),
        .addr       (mem_addr)
    );

    tcs_save_buf u_save (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .ctx_i  (save_ctx),
        .sel    (idx[LIVE_IDX_W-1:0]),
        .wdata  (mem_wdata)
    );

    tcs_load_regs u_load (
        .clk       (clk),
        .rst       (rst),
        .load_fire (load_fire),
        .idx       (idx),
        .rdata     (mem_rdata),
        .pgdir_o   (pgdir_base),
        .stack_o   (stack),
        .flags_o   (flags),
        .live_o    (load_ctx)
    );

    genvar l;
    generate
        for (l = 0; l < PRIV_LEVELS; l++) begin : g_stack_out
            assign stk_off[l*WORD_W +: WORD_W] = stack[l].offset;
            assign stk_sel[l*SEL_W +: SEL_W]   = stack[l].selector;
        end
    endgenerate

    assign trap_flag  = flags.trap;
    assign io_map_ofs = flags.io_map;
    assign dbg_req    = done && flags.trap;

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R8
    dbg_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        dbg_req |-> done);

    // R2
    valid_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> busy);

endmodule

// File: tb/task_ctx_switcher_bench.sv
`timescale 1ns/1ps
module task_ctx_switcher_bench;
    import task_ctx_pkg::*;

    localparam int AW       = 32;
    localparam int MEM_WDS  = 1024;
    localparam int WATCHDOG = 20000;

    logic                          clk = 1'b0;
    logic                          rst = 1'b1;
    logic                          start = 1'b0;
    logic [AW-1:0]                 old_base = '0;
    logic [AW-1:0]                 new_base = '0;
    logic [LIVE_WORDS*32-1:0]      save_ctx = '0;
    logic                          mem_valid, mem_we;
    logic [AW-1:0]                 mem_addr;
    logic [31:0]                   mem_wdata, mem_rdata;
    logic                          mem_ready = 1'b1;
    logic                          busy, done, dbg_req, trap_flag;
    logic [31:0]                   pgdir_base;
    logic [PRIV_LEVELS*32-1:0]     stk_off;
    logic [PRIV_LEVELS*16-1:0]     stk_sel;
    logic [15:0]                   io_map_ofs;
    logic [LIVE_WORDS*32-1:0]      load_ctx;

    always #2.5 clk = ~clk;

    task_ctx_switcher #(.ADDR_W(AW)) u_task_ctx_switcher (
        .clk(clk), .rst(rst), .start(start), .old_base(old_base), .new_base(new_base),
        .save_ctx(save_ctx), .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .dbg_req(dbg_req), .pgdir_base(pgdir_base),
        .stk_off(stk_off), .stk_sel(stk_sel), .trap_flag(trap_flag),
        .io_map_ofs(io_map_ofs), .load_ctx(load_ctx)
    );

    // ---------------- memory model ----------------
    logic [31:0] mem [0:MEM_WDS-1];
    assign mem_rdata = mem[mem_addr[11:2]];

    function automatic logic [31:0] fill_word(input int i);
        return 32'h5A00_0000 ^ (i * 32'h0001_0003);
    endfunction

    always @(posedge clk) begin
        if (mem_valid && mem_ready && mem_we) mem[mem_addr[11:2]] = mem_wdata;
    end

    // ---------------- checking ----------------
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit rand_ready = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // ---------------- reference model ----------------
    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
    } xfer_t;

    typedef struct packed {
        logic [31:0]                   pgdir;
        logic [PRIV_LEVELS-1:0][31:0]  off;
        logic [PRIV_LEVELS-1:0][15:0]  sel;
        logic                          trap;
        logic [15:0]                   io;
        logic [LIVE_WORDS-1:0][31:0]   live;
    } fields_t;

    xfer_t   q[$];
    int      ms = 0;          // 0 idle, 1 transfers, 2 flag check, 3 done
    bit      stall_prev = 0;
    fields_t pend = '0;
    fields_t expd = '0;

    task automatic build_switch();
        logic [31:0] img [AREA_WORDS];
        int nb;
        int wi;
        xfer_t x;
        nb = int'(new_base >> 2);
        for (int i = 0; i < AREA_WORDS; i++) img[i] = mem[nb + i];
        for (int w = 0; w < LIVE_WORDS; w++) begin
            x.we   = 1'b1;
            x.addr = old_base + 32'(32 + 4 * w);
            x.data = save_ctx[w*32 +: 32];
            q.push_back(x);
            wi = int'(old_base >> 2) + 8 + w;
            if (wi >= nb && wi < nb + AREA_WORDS) img[wi - nb] = x.data;
        end
        for (int i = 0; i < AREA_WORDS; i++) begin
            x.we   = 1'b0;
            x.addr = new_base + 32'(4 * i);
            x.data = img[i];
            q.push_back(x);
        end
        pend.pgdir = img[7];
        for (int l = 0; l < PRIV_LEVELS; l++) begin
            pend.off[l] = img[1 + 2 * l];
            pend.sel[l] = img[2 + 2 * l][15:0];
        end
        pend.trap = img[25][0];
        pend.io   = img[25][31:16];
        for (int w = 0; w < LIVE_WORDS; w++) pend.live[w] = img[8 + w];
    endtask

    always @(posedge clk) begin
        stall_prev = (ms == 1) && !mem_ready;
        if (rst) begin
            ms = 0;
            q.delete();
            expd = '0;
            stall_prev = 0;
        end else begin
            case (ms)
                0: if (start) begin build_switch(); ms = 1; end
                1: if (mem_ready) begin
                       void'(q.pop_front());
                       if (q.size() == 0) begin ms = 2; expd = pend; end
                   end
                2: ms = 3;
                default: ms = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        string tag;
        if (!rst) begin
            chk(busy == (ms != 0), "R9 busy", 64'(busy), 64'(ms != 0));
            chk(done == (ms == 3), "R9 done", 64'(done), 64'(ms == 3));
            chk(dbg_req == (ms == 3 && expd.trap), "R8 debug request", 64'(dbg_req), 64'(ms == 3 && expd.trap));
            chk(mem_valid == (ms == 1), "R4 request valid", 64'(mem_valid), 64'(ms == 1));
            if (ms == 1 && q.size() > 0) begin
                tag = stall_prev ? "R3 held request" : (q[0].we ? "R2 save write" : "R4 load read");
                chk(mem_we == q[0].we, tag, 64'(mem_we), 64'(q[0].we));
                chk(mem_addr == q[0].addr, tag, 64'(mem_addr), 64'(q[0].addr));
                if (q[0].we) chk(mem_wdata == q[0].data, tag, 64'(mem_wdata), 64'(q[0].data));
            end
            if (ms == 0 || ms == 3) begin
                chk(pgdir_base == expd.pgdir, "R6 page-directory base", 64'(pgdir_base), 64'(expd.pgdir));
                for (int l = 0; l < PRIV_LEVELS; l++) begin
                    chk(stk_off[l*32 +: 32] == expd.off[l], "R5 stack offset", 64'(stk_off[l*32 +: 32]), 64'(expd.off[l]));
                    chk(stk_sel[l*16 +: 16] == expd.sel[l], "R5 stack selector", 64'(stk_sel[l*16 +: 16]), 64'(expd.sel[l]));
                end
                chk(trap_flag == expd.trap, "R8 trap flag", 64'(trap_flag), 64'(expd.trap));
                chk(io_map_ofs == expd.io, "R8 io map offset", 64'(io_map_ofs), 64'(expd.io));
                for (int w = 0; w < LIVE_WORDS; w++)
                    chk(load_ctx[w*32 +: 32] == expd.live[w], "R7 loaded context", 64'(load_ctx[w*32 +: 32]), 64'(expd.live[w]));
            end
        end
    end

    // ready pattern
    always @(negedge clk) begin
        mem_ready = rand_ready ? ($urandom_range(0, 2) != 0) : 1'b1;
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            chk(1'b0, "R9 watchdog", 64'(cyc), 64'(WATCHDOG));
            finish_up();
        end
    end

    // ---------------- stimulus ----------------
    task automatic set_ctx(input logic [31:0] seed);
        for (int w = 0; w < LIVE_WORDS; w++) save_ctx[w*32 +: 32] = seed ^ (w * 32'h0101_0011);
    endtask

    task automatic kick(input logic [31:0] ob, input logic [31:0] nb);
        @(negedge clk);
        old_base = ob;
        new_base = nb;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (ms != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < MEM_WDS; i++) mem[i] = fill_word(i);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: state after reset
        chk(busy == 1'b0, "R1 busy after reset", 64'(busy), 64'd0);
        chk(mem_valid == 1'b0, "R1 valid after reset", 64'(mem_valid), 64'd0);
        chk(pgdir_base == 32'd0 && io_map_ofs == 16'd0 && !trap_flag, "R1 fields after reset", 64'(pgdir_base), 64'd0);
        chk(load_ctx == '0, "R1 context after reset", 64'(load_ctx[63:0]), 64'd0);

        // R2 R4 R5 R6 R7 R8: plain switch, always ready, trap clear
        mem[(32'h200 >> 2) + 25] = 32'h1234_0000;
        set_ctx(32'hC0DE_0001);
        kick(32'h100, 32'h200);
        wait_idle();

        // R3 R8 R10: random ready, trap set, intruding start mid-run
        rand_ready = 1;
        mem[(32'h400 >> 2) + 25] = 32'hBEEF_0001;
        set_ctx(32'hC0DE_0002);
        kick(32'h300, 32'h400);
        repeat (6) @(negedge clk);
        set_ctx(32'hDEAD_0003);
        kick(32'h800, 32'h900);
        repeat (4) @(negedge clk);
        kick(32'h800, 32'h900);
        wait_idle();
        for (int w = 0; w < LIVE_WORDS; w++) begin
            int a;
            a = (32'h800 >> 2) + 8 + w;
            chk(mem[a] == fill_word(a), "R10 ignored start wrote nothing", 64'(mem[a]), 64'(fill_word(a)));
        end

        // R7: same segment saved then loaded
        mem[(32'h600 >> 2) + 25] = 32'h0068_0001;
        set_ctx(32'h7777_0004);
        kick(32'h600, 32'h600);
        wait_idle();
        chk(load_ctx == save_ctx, "R7 round trip", 64'(load_ctx[63:0]), 64'(save_ctx[63:0]));

        // R1: reset in the middle of a switch
        set_ctx(32'h1111_0005);
        kick(32'hA00, 32'hB00);
        repeat (8) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && mem_valid == 1'b0, "R1 idle after mid-run reset", 64'(busy), 64'd0);
        chk(pgdir_base == 32'd0 && load_ctx == '0, "R1 cleared after mid-run reset", 64'(pgdir_base), 64'd0);

        // recovery switch after reset, trap clear
        rand_ready = 0;
        set_ctx(32'h2222_0006);
        kick(32'hC00, 32'h200);
        wait_idle();

        repeat (3) @(negedge clk);
        finish_up();
    end

endmodule